// File: doc/BRIEF.md
# Binary and Decimal Add-With-Carry Unit

This block is the 8-bit add-with-carry datapath of a small accumulator processor. On each accepted operation it adds an accumulator operand, a memory operand and the stored carry flag. It then registers the sum and updates four status flags: negative, overflow, zero and carry. One adder path per mode feeds a single result register. In binary mode the operands are two's-complement or unsigned bytes. In decimal mode they are packed two-digit BCD, and each nibble is corrected on its own.

There is no add-without-carry operation. A plain add needs the carry flag cleared first, through the carry-load port. Chained additions work because the carry flag keeps its value between operations. Add the low bytes first with carry clear, then add each higher byte without touching carry. Loading a set carry before an add of an inverted accumulator gives a reverse subtraction.

Each cycle the control logic picks one of three operation codes, with the add taking priority:
- `OP_ADD` when `add_valid` is high.
- `OP_CARRY` when `add_valid` is low and `carry_load` is high.
- `OP_HOLD` otherwise.

All transitions happen on a rising clock edge. A synchronous reset returns every register to zero.

Top module: `adc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `sum_q` and all four flags become 0.
- R2: In binary mode (`dec_mode`=0), an add stores (acc + mem + carry) mod 256 in `sum_q`. It sets `flag_c` to bit 8 of that full sum.
- R3: The incoming carry of every add is the current `flag_c`. No other input supplies a carry to the adder.
- R4: In decimal mode (`dec_mode`=1), with valid packed-BCD operands (upper nibble is the tens digit, lower nibble is the units digit), `sum_q` holds the packed-BCD value of (acc + mem + carry) mod 100. `flag_c` is set exactly when that decimal sum exceeds 99.
- R5: After a binary add, `flag_n` equals bit 7 of the stored result.
- R6: After a binary add, `flag_z` is 1 when the stored result is zero and 0 otherwise.
- R7: After a binary add, `flag_v` is 1 exactly when both operands have the same bit 7 and the result's bit 7 differs from it.
- R8: A decimal add leaves `flag_n`, `flag_v` and `flag_z` unchanged.
- R9: With `add_valid` low and `carry_load` high, `flag_c` takes `carry_value` and `sum_q` holds. When both are high in the same cycle, the add wins and `carry_value` is ignored.
- R10: With `add_valid` and `carry_load` both low, `sum_q` and all flags hold their values.
- R11: A multi-byte binary sum built low byte first, with carry cleared only before the first byte, equals the full-width sum modulo 2^(8*bytes).
- R12: Loading carry=1, then adding the bitwise inverse of X to a value M in binary mode, gives (M - X) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| add_valid | input | 1 | Perform an add this cycle |
| dec_mode | input | 1 | 1 = packed-BCD add, 0 = binary add |
| acc_in | input | 8 | Accumulator operand |
| mem_in | input | 8 | Memory operand |
| carry_load | input | 1 | Write `carry_value` into the carry flag |
| carry_value | input | 1 | Value for the carry write |
| sum_q | output | 8 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
An add and a carry write can both be requested in the same cycle. The add must win, using the old carry as its carry-in and storing its own carry-out. The bench raises both strobes together in directed cases, using a `carry_value` opposite to the expected carry-out. It also does this at random during the mixed binary/decimal stream. The result and carry are judged against a reference model that applies only the add.

// File: rtl/adc_pkg.sv
package adc_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CARRY = 2'd1,
        OP_ADD   = 2'd2
    } adc_op_e;
endpackage

// File: rtl/adc_bin_add.sv
module adc_bin_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
        ovf  = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/adc_bcd_add.sv
module adc_bcd_add #(
    parameter int DIGITS = 2
) (
    input  logic [4*DIGITS-1:0] a,
    input  logic [4*DIGITS-1:0] b,
    input  logic                cin,
    output logic [4*DIGITS-1:0] sum,
    output logic                cout
);
    logic [DIGITS:0] chain;

    assign chain[0] = cin;
    assign cout     = chain[DIGITS];

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        logic [4:0] raw;
        logic [4:0] fixed;
        logic       dc;

        always_comb begin
            raw = {1'b0, a[4*d +: 4]} + {1'b0, b[4*d +: 4]} + {4'd0, chain[d]};
            if (raw > 5'd9) begin
                fixed = raw + 5'd6;
                dc    = 1'b1;
            end else begin
                fixed = raw;
                dc    = 1'b0;
            end
        end

        assign sum[4*d +: 4] = fixed[3:0];
        assign chain[d+1]    = dc;

        always_comb begin
            if (!$isunknown({a[4*d +: 4], b[4*d +: 4], chain[d]}) &&
                a[4*d +: 4] <= 4'd9 && b[4*d +: 4] <= 4'd9) begin
                AST_BCD_DIGIT_LEGAL: assert (fixed[3:0] <= 4'd9); // R4
            end
        end
    end
endmodule

// File: rtl/adc_unit.sv
module adc_unit
    import adc_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                add_valid,
    input  logic                dec_mode,
    input  logic [4*DIGITS-1:0] acc_in,
    input  logic [4*DIGITS-1:0] mem_in,
    input  logic                carry_load,
    input  logic                carry_value,
    output logic [4*DIGITS-1:0] sum_q,
    output logic                flag_n,
    output logic                flag_v,
    output logic                flag_z,
    output logic                flag_c
);
    localparam int W = 4 * DIGITS;

    adc_op_e     op;
    logic [W-1:0] bin_sum;
    logic [W-1:0] bcd_sum;
    logic         bin_co;
    logic         bin_ov;
    logic         bcd_co;

    adc_bin_add #(.W(W)) u_bin (
        .a    (acc_in),
        .b    (mem_in),
        .cin  (flag_c),
        .sum  (bin_sum),
        .cout (bin_co),
        .ovf  (bin_ov)
    );

    adc_bcd_add #(.DIGITS(DIGITS)) u_bcd (
        .a    (acc_in),
        .b    (mem_in),
        .cin  (flag_c),
        .sum  (bcd_sum),
        .cout (bcd_co)
    );

    always_comb begin
        if (add_valid)       op = OP_ADD;
        else if (carry_load) op = OP_CARRY;
        else                 op = OP_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q  <= '0;
            flag_n <= 1'b0;
            flag_v <= 1'b0;
            flag_z <= 1'b0;
            flag_c <= 1'b0;
        end else begin
            unique case (op)
                OP_ADD: begin
                    if (dec_mode) begin
                        sum_q  <= bcd_sum;
                        flag_c <= bcd_co;
                    end else begin
                        sum_q  <= bin_sum;
                        flag_c <= bin_co;
                        flag_n <= bin_sum[W-1];
                        flag_z <= (bin_sum == '0);
                        flag_v <= bin_ov;
                    end
                end
                OP_CARRY: flag_c <= carry_value;
                OP_HOLD:  ;
                default:  ;
            endcase
        end
    end

    AST_BIN_NEG: assert property (@(posedge clk) disable iff (rst)
        add_valid && !dec_mode |=> flag_n == sum_q[W-1]); // R5
    AST_BIN_ZERO: assert property (@(posedge clk) disable iff (rst)
        add_valid && !dec_mode |=> flag_z == (sum_q == '0)); // R6
    AST_BIN_OVF: assert property (@(posedge clk) disable iff (rst)
        add_valid && !dec_mode |=> flag_v == (($past(acc_in[W-1]) == $past(mem_in[W-1])) && (sum_q[W-1] != $past(acc_in[W-1])))); // R7
    AST_CARRY_IN: assert property (@(posedge clk) disable iff (rst)
        add_valid && !dec_mode && acc_in == '0 && mem_in == '0 |=> sum_q == {{(W-1){1'b0}}, $past(flag_c)}); // R3
    AST_DEC_KEEP: assert property (@(posedge clk) disable iff (rst)
        add_valid && dec_mode |=> $stable(flag_n) && $stable(flag_v) && $stable(flag_z)); // R8
    AST_CARRY_WRITE: assert property (@(posedge clk) disable iff (rst)
        carry_load && !add_valid |=> flag_c == $past(carry_value) && $stable(sum_q)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !carry_load && !add_valid |=> $stable(sum_q) && $stable(flag_c) && $stable(flag_n) && $stable(flag_v) && $stable(flag_z)); // R10
endmodule

// File: tb/adc_unit_tb_top.sv
module adc_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       add_valid;
    logic       dec_mode;
    logic [7:0] acc_in;
    logic [7:0] mem_in;
    logic       carry_load;
    logic       carry_value;
    logic [7:0] sum_q;
    logic       flag_n, flag_v, flag_z, flag_c;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_sum;
    logic       m_n, m_v, m_z, m_c;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_unit dut_i (
        .clk(clk), .rst(rst), .add_valid(add_valid), .dec_mode(dec_mode),
        .acc_in(acc_in), .mem_in(mem_in), .carry_load(carry_load),
        .carry_value(carry_value), .sum_q(sum_q), .flag_n(flag_n),
        .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c)
    );

    function automatic int bcd_val(input logic [7:0] x);
        return int'(x[7:4]) * 10 + int'(x[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, {8'd0, sum_q}, {8'd0, m_sum});
        chk(req, {12'd0, flag_n, flag_v, flag_z, flag_c}, {12'd0, m_n, m_v, m_z, m_c});
    endtask

    // model applies requirements R2..R10 to one cycle of stimulus
    task automatic step(input logic v, input logic d, input logic [7:0] a,
                        input logic [7:0] m, input logic cl, input logic cv);
        int full;
        @(negedge clk);
        add_valid = v; dec_mode = d; acc_in = a; mem_in = m;
        carry_load = cl; carry_value = cv;
        if (v) begin
            if (d) begin
                full  = bcd_val(a) + bcd_val(m) + int'(m_c);
                m_sum = to_bcd(full % 100);
                m_c   = (full > 99);
            end else begin
                full  = int'(a) + int'(m) + int'(m_c);
                m_sum = full[7:0];
                m_c   = full[8];
                m_n   = m_sum[7];
                m_z   = (m_sum == 8'd0);
                m_v   = (a[7] == m[7]) && (m_sum[7] != a[7]);
            end
        end else if (cl) begin
            m_c = cv;
        end
        @(posedge clk);
        #1;
        add_valid = 1'b0; carry_load = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [23:0] xa, xb;
        logic [24:0] wide;
        logic [23:0] got;
        void'($urandom(32'd1234));
        rst = 1'b1; add_valid = 0; dec_mode = 0; acc_in = 0; mem_in = 0;
        carry_load = 0; carry_value = 0;
        m_sum = 0; m_n = 0; m_v = 0; m_z = 0; m_c = 0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset state");
        // dirty registers, then reset again
        @(negedge clk); rst = 1'b0;
        step(1, 0, 8'hFF, 8'h81, 0, 0);
        check_all("R2 R7 pre-reset add");
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        m_sum = 0; m_n = 0; m_v = 0; m_z = 0; m_c = 0;
        check_all("R1 reset clears");
        @(negedge clk); rst = 1'b0;

        // R3 carry-in comes from flag
        step(0, 0, 0, 0, 1, 1);
        check_all("R9 carry write");
        step(1, 0, 8'h00, 8'h00, 0, 0);
        check_all("R3 carry-in used");
        chk("R3 sum one", {8'd0, sum_q}, 16'h0001);
        // R6 zero and R2 wrap
        step(1, 0, 8'hFF, 8'h01, 0, 0);
        check_all("R6 zero with carry out");
        chk("R6 z set", {15'd0, flag_z}, 16'h0001);
        // R7 overflow positive and negative
        step(0, 0, 0, 0, 1, 0);
        step(1, 0, 8'h7F, 8'h01, 0, 0);
        check_all("R7 pos overflow");
        chk("R5 n set", {15'd0, flag_n}, 16'h0001);
        step(1, 0, 8'h80, 8'hFF, 0, 0);
        check_all("R7 neg overflow");
        // R4 decimal, R8 keep flags
        step(0, 0, 0, 0, 1, 0);
        step(1, 1, 8'h58, 8'h46, 0, 0);
        check_all("R4 R8 bcd 58+46");
        chk("R4 bcd result", {8'd0, sum_q}, 16'h0004);
        step(1, 1, 8'h99, 8'h00, 0, 0);
        check_all("R4 bcd 99+0+1");
        step(1, 1, 8'h09, 8'h09, 0, 0);
        check_all("R4 bcd digit carry");
        // R9 both strobes: add wins
        step(1, 0, 8'hF0, 8'h20, 1, 0);
        check_all("R9 add beats carry write");
        chk("R9 carry from add", {15'd0, flag_c}, 16'h0001);
        // R10 idle holds
        step(0, 0, 8'h12, 8'h34, 0, 1);
        check_all("R10 idle hold");

        // R11 three-byte chain
        for (int k = 0; k < 8; k++) begin
            r  = $urandom; xa = r[23:0];
            r  = $urandom; xb = r[23:0];
            wide = {1'b0, xa} + {1'b0, xb};
            step(0, 0, 0, 0, 1, 0);
            step(1, 0, xa[7:0], xb[7:0], 0, 0);   got[7:0]   = sum_q;
            step(1, 0, xa[15:8], xb[15:8], 0, 0); got[15:8]  = sum_q;
            step(1, 0, xa[23:16], xb[23:16], 0, 0); got[23:16] = sum_q;
            chk("R11 chained sum", {8'd0, got[23:8]}, {8'd0, wide[23:8]});
            chk("R11 chained low/carry", {7'd0, flag_c, got[7:0]}, {7'd0, wide[24], wide[7:0]});
        end

        // R12 reverse subtraction
        for (int k = 0; k < 8; k++) begin
            r = $urandom;
            step(0, 0, 0, 0, 1, 1);
            step(1, 0, ~r[7:0], r[15:8], 0, 0);
            chk("R12 reverse subtract", {8'd0, sum_q}, {8'd0, r[15:8] - r[7:0]});
        end

        // mixed random stream
        for (int k = 0; k < 400; k++) begin
            logic d;
            logic [7:0] a, m;
            r = $urandom;
            d = r[0];
            if (d) begin
                a = to_bcd(int'(r[15:8]) % 100);
                m = to_bcd(int'(r[23:16]) % 100);
            end else begin
                a = r[15:8]; m = r[23:16];
            end
            step(r[26:24] != 3'd0, d, a, m, r[27], r[28]);
            check_all("R2 R4 R9 R10 random stream");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule